// File: doc/BRIEF.md
# Secure Doorbell Mailbox Registers

This block is a pair of doorbell mailboxes between an application processor and a system control processor. Each direction has one 32-bit status word in which every bit stands for a message slot. A sender raises a slot by writing a mask to that channel's set register. The receiver acknowledges the slot by writing the same mask to the channel's clear register. Each channel has a level interrupt that stays high for as long as its status word is nonzero.

Each side reaches the registers through its own plain 32-bit register port. A port carries an address, a write enable, write data, a security qualifier and combinational read data. A write takes effect at the clock edge where its write enable is high. The two ports may write in the same cycle. Status bit 31 is not a slot. It is a sticky flag that records a write attempt from a non-secure master, so only slots 0 to 30 carry doorbells.

The ports carry no data stream. They are control and status register ports, so they have no valid/ready handshake and never apply back-pressure.

Top module: `mbox_doorbell`

## Requirements
- R1: After reset both status words read 0 and both interrupts are low.
- R2: The channel toward the application processor has its status at 0x200, its set register at 0x208 and its clear register at 0x210. The channel toward the control processor has its status at 0x300, its set register at 0x308 and its clear register at 0x310. Both ports reach all six registers.
- R3: A secure write to a set register ORs bits 30:0 of the written data into that status word at the write edge. Bits written as 0 keep their value.
- R4: A secure write to a clear register clears every status bit written as 1 at the write edge. Other bits keep their value.
- R5: Bit 31 written through a set register has no effect on the status word.
- R6: A non-secure write to any of a channel's three registers changes no slot bit (30:0). It sets bit 31 of that channel's status word.
- R7: Once bit 31 is set, it stays set until a secure write of 1 to bit 31 of that channel's clear register. A non-secure clear does not clear it.
- R8: If a set and a clear of the same bit land on one channel in the same cycle, the bit ends up set. A non-secure attempt in the same cycle as a secure clear of bit 31 leaves bit 31 set.
- R9: `irq_to_proc` (channel 0x200) and `irq_to_ctrl` (channel 0x300) are high in exactly the cycles in which the matching status word is nonzero, with no added register delay.
- R10: Read data is combinational on the address. A status offset returns its status word. Set, clear and unmapped offsets return 0. A read has no side effect.
- R11: A secure write to a status offset is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| proc_addr | input | 12 | Processor-side register byte address |
| proc_we | input | 1 | Processor-side write enable |
| proc_wdata | input | 32 | Processor-side write data |
| proc_secure | input | 1 | Processor-side write is secure when 1 |
| proc_rdata | output | 32 | Processor-side read data |
| ctrl_addr | input | 12 | Controller-side register byte address |
| ctrl_we | input | 1 | Controller-side write enable |
| ctrl_wdata | input | 32 | Controller-side write data |
| ctrl_secure | input | 1 | Controller-side write is secure when 1 |
| ctrl_rdata | output | 32 | Controller-side read data |
| irq_to_proc | output | 1 | High while status 0x200 is nonzero |
| irq_to_ctrl | output | 1 | High while status 0x300 is nonzero |

## Verification
The bench goes after bit 31 in each of its roles:
- Written through a set register, it must be dropped. A design that let it through would raise a false security flag and hold the interrupt high.
- It must survive a secure clear that leaves bit 31 at 0.
- It must survive a non-secure clear. A design that honoured non-secure writes would let an untrusted master erase the evidence.

The bench also drives a set and a clear of the same slot from the two ports in one edge. A design that let the clear win would lose a doorbell. Reads of set, clear and unmapped offsets, and secure writes to the status offsets, are checked to leave the status words untouched. A model that mirrors the expected state is compared with both read ports and both interrupts on every clock.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int ADDR_W   = 12;
  localparam int DATA_W   = 32;
  localparam int NUM_CH   = 2;
  localparam int NUM_PORT = 2;
  localparam int FLAG_BIT = DATA_W - 1;
  localparam logic [ADDR_W-1:0] OFS_SET = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_CLR = 12'h010;
  localparam logic [DATA_W-1:0] SLOT_MASK = {1'b0, {(DATA_W-1){1'b1}}};

  typedef enum logic [1:0] {REG_NONE, REG_STAT, REG_SET, REG_CLR} reg_kind_e;

  // channel 0 rings the application processor, channel 1 the control processor
  function automatic logic [ADDR_W-1:0] ch_base(input int ch);
    return (ch == 0) ? 12'h200 : 12'h300;
  endfunction

  function automatic reg_kind_e decode(input logic [ADDR_W-1:0] a, input int ch);
    if (a == ch_base(ch))                 return REG_STAT;
    else if (a == ch_base(ch) + OFS_SET)  return REG_SET;
    else if (a == ch_base(ch) + OFS_CLR)  return REG_CLR;
    else                                  return REG_NONE;
  endfunction
endpackage

// File: rtl/mbox_port_dec.sv
module mbox_port_dec
  import mbox_pkg::*;
(
  input  logic [ADDR_W-1:0]              addr,
  input  logic                           we,
  input  logic [DATA_W-1:0]              wdata,
  input  logic                           secure,
  output logic [NUM_CH-1:0][DATA_W-1:0]  set_req,
  output logic [NUM_CH-1:0][DATA_W-1:0]  clr_req,
  output logic [NUM_CH-1:0]              ns_hit
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    reg_kind_e kind;
    assign kind = decode(addr, c);
    always_comb begin
      set_req[c] = '0;
      clr_req[c] = '0;
      ns_hit[c]  = 1'b0;
      if (we && kind != REG_NONE) begin
        if (!secure) ns_hit[c] = 1'b1;
        else if (kind == REG_SET) set_req[c] = wdata & SLOT_MASK;
        else if (kind == REG_CLR) clr_req[c] = wdata;
      end
    end
  end
endmodule

// File: rtl/mbox_rd_mux.sv
module mbox_rd_mux
  import mbox_pkg::*;
(
  input  logic [ADDR_W-1:0]              addr,
  input  logic [NUM_CH-1:0][DATA_W-1:0]  status,
  output logic [DATA_W-1:0]              rdata
);
  always_comb begin
    rdata = '0;
    for (int c = 0; c < NUM_CH; c++)
      if (decode(addr, c) == REG_STAT) rdata = status[c];
  end
endmodule

// File: rtl/mbox_chan.sv
module mbox_chan
  import mbox_pkg::*;
(
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_PORT-1:0][DATA_W-1:0]  set_req,
  input  logic [NUM_PORT-1:0][DATA_W-1:0]  clr_req,
  input  logic [NUM_PORT-1:0]              ns_hit,
  output logic [DATA_W-1:0]                status,
  output logic                             irq
);
  logic [DATA_W-1:0] set_any, clr_any, flag_set, nxt;
  logic              ns_any;

  always_comb begin
    set_any = '0;
    clr_any = '0;
    for (int p = 0; p < NUM_PORT; p++) begin
      set_any |= set_req[p];
      clr_any |= clr_req[p];
    end
    ns_any   = |ns_hit;
    flag_set = '0;
    flag_set[FLAG_BIT] = ns_any;
    // set (and the non-secure flag) win over a same-cycle clear
    nxt = (status & ~clr_any) | set_any | flag_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= nxt;
  end

  assign irq = |status;

  a_r3_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_any) |=> ((status & $past(set_any)) == $past(set_any)));
  a_r4_clear_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_any & ~set_any & ~flag_set)) |=>
      ((status & $past(clr_any & ~set_any & ~flag_set)) == '0));
  a_r6_flag_raised: assert property (@(posedge clk) disable iff (!rst_n)
    ns_any |=> status[FLAG_BIT]);
  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (status[FLAG_BIT] && !clr_any[FLAG_BIT]) |=> status[FLAG_BIT]);
  a_r11_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|set_any) && !(|clr_any) && !ns_any) |=> $stable(status));
endmodule

// File: rtl/mbox_doorbell.sv
module mbox_doorbell
  import mbox_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] proc_addr,
  input  logic              proc_we,
  input  logic [DATA_W-1:0] proc_wdata,
  input  logic              proc_secure,
  output logic [DATA_W-1:0] proc_rdata,
  input  logic [ADDR_W-1:0] ctrl_addr,
  input  logic              ctrl_we,
  input  logic [DATA_W-1:0] ctrl_wdata,
  input  logic              ctrl_secure,
  output logic [DATA_W-1:0] ctrl_rdata,
  output logic              irq_to_proc,
  output logic              irq_to_ctrl
);
  logic [NUM_PORT-1:0][ADDR_W-1:0]             p_addr;
  logic [NUM_PORT-1:0]                         p_we, p_sec;
  logic [NUM_PORT-1:0][DATA_W-1:0]             p_wdata, p_rdata;
  logic [NUM_PORT-1:0][NUM_CH-1:0][DATA_W-1:0] set_req, clr_req;
  logic [NUM_PORT-1:0][NUM_CH-1:0]             ns_hit;
  logic [NUM_CH-1:0][NUM_PORT-1:0][DATA_W-1:0] ch_set, ch_clr;
  logic [NUM_CH-1:0][NUM_PORT-1:0]             ch_ns;
  logic [NUM_CH-1:0][DATA_W-1:0]               status;
  logic [NUM_CH-1:0]                           irq;

  assign p_addr  = {ctrl_addr, proc_addr};
  assign p_we    = {ctrl_we, proc_we};
  assign p_sec   = {ctrl_secure, proc_secure};
  assign p_wdata = {ctrl_wdata, proc_wdata};
  assign proc_rdata = p_rdata[0];
  assign ctrl_rdata = p_rdata[1];

  for (genvar p = 0; p < NUM_PORT; p++) begin : g_port
    mbox_port_dec u_dec (
      .addr(p_addr[p]), .we(p_we[p]), .wdata(p_wdata[p]), .secure(p_sec[p]),
      .set_req(set_req[p]), .clr_req(clr_req[p]), .ns_hit(ns_hit[p]));
    mbox_rd_mux u_rd (.addr(p_addr[p]), .status(status), .rdata(p_rdata[p]));
    for (genvar c = 0; c < NUM_CH; c++) begin : g_x
      assign ch_set[c][p] = set_req[p][c];
      assign ch_clr[c][p] = clr_req[p][c];
      assign ch_ns[c][p]  = ns_hit[p][c];
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    mbox_chan u_chan (
      .clk(clk), .rst_n(rst_n), .set_req(ch_set[c]), .clr_req(ch_clr[c]),
      .ns_hit(ch_ns[c]), .status(status[c]), .irq(irq[c]));
  end

  assign irq_to_proc = irq[0];
  assign irq_to_ctrl = irq[1];

  a_r9_irq_matches_read: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_addr == ch_base(0)) |-> (irq_to_proc == (proc_rdata != '0)));
  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (decode(ctrl_addr, 0) != REG_STAT && decode(ctrl_addr, 1) != REG_STAT)
      |-> (ctrl_rdata == '0));
endmodule

// File: tb/mbox_doorbell_bench.sv
module mbox_doorbell_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [11:0] addr [2];
  logic        we   [2];
  logic [31:0] wd   [2];
  logic        sec  [2];
  logic [31:0] proc_rdata, ctrl_rdata;
  logic        irq_to_proc, irq_to_ctrl;
  int checks = 0, fails = 0;
  logic [31:0] m [2];   // model status: [0] at 0x200, [1] at 0x300
  bit done = 0;

  always #4 clk = ~clk;   // 125 MHz

  mbox_doorbell u_mbox_doorbell (
    .clk(clk), .rst_n(rst_n),
    .proc_addr(addr[0]), .proc_we(we[0]), .proc_wdata(wd[0]), .proc_secure(sec[0]),
    .proc_rdata(proc_rdata),
    .ctrl_addr(addr[1]), .ctrl_we(we[1]), .ctrl_wdata(wd[1]), .ctrl_secure(sec[1]),
    .ctrl_rdata(ctrl_rdata),
    .irq_to_proc(irq_to_proc), .irq_to_ctrl(irq_to_ctrl));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [11:0] a);
    if (a == 12'h200) return m[0];
    if (a == 12'h300) return m[1];
    return 32'h0;
  endfunction

  // behavioural reference: accumulate per-channel effects of both ports
  always @(posedge clk) begin
    if (!rst_n) begin
      m[0] = 0; m[1] = 0;
    end else begin
      for (int c = 0; c < 2; c++) begin
        logic [31:0] s, k;
        bit f;
        int base;
        s = 0; k = 0; f = 0;
        base = (c == 0) ? 'h200 : 'h300;
        for (int p = 0; p < 2; p++) begin
          if (we[p] && (addr[p] == base || addr[p] == base + 8 || addr[p] == base + 16)) begin
            if (!sec[p]) f = 1;
            else if (addr[p] == base + 8) s |= wd[p] & 32'h7fff_ffff;
            else if (addr[p] == base + 16) k |= wd[p];
          end
        end
        m[c] = (m[c] & ~k) | s;
        if (f) m[c][31] = 1'b1;
      end
    end
  end

  // per-cycle comparison, away from the edge
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      chk("R10 proc read vs model", proc_rdata, exp_rd(addr[0]));
      chk("R10 ctrl read vs model", ctrl_rdata, exp_rd(addr[1]));
      chk("R9 irq_to_proc vs model", {31'b0, irq_to_proc}, {31'b0, m[0] != 0});
      chk("R9 irq_to_ctrl vs model", {31'b0, irq_to_ctrl}, {31'b0, m[1] != 0});
    end
  end

  task automatic wr2(input logic [11:0] a0, input logic w0, input logic [31:0] d0, input logic s0,
                     input logic [11:0] a1, input logic w1, input logic [31:0] d1, input logic s1);
    @(negedge clk);
    addr[0] = a0; we[0] = w0; wd[0] = d0; sec[0] = s0;
    addr[1] = a1; we[1] = w1; wd[1] = d1; sec[1] = s1;
    @(negedge clk);
    we[0] = 0; we[1] = 0;
  endtask

  task automatic wr(input int p, input logic [11:0] a, input logic [31:0] d, input logic s);
    if (p == 0) wr2(a, 1, d, s, 12'h0, 0, 0, 1);
    else        wr2(12'h0, 0, 0, 1, a, 1, d, s);
  endtask

  task automatic rd(input int p, input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    addr[p] = a; we[p] = 0;
    @(posedge clk); #2;
    chk(tag, (p == 0) ? proc_rdata : ctrl_rdata, exp);
  endtask

  task automatic irqs(input logic ep, input logic ec, input string tag);
    chk(tag, {30'b0, irq_to_proc, irq_to_ctrl}, {30'b0, ep, ec});
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < 2; p++) begin addr[p] = 0; we[p] = 0; wd[p] = 0; sec[p] = 1; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(0, 12'h200, 32'h0, "R1 reset status 0x200");
    rd(1, 12'h300, 32'h0, "R1 reset status 0x300");
    irqs(0, 0, "R1 irqs low after reset");

    wr(0, 12'h308, 32'h0000_0005, 1);
    rd(0, 12'h300, 32'h0000_0005, "R3 set mask");
    irqs(0, 1, "R9 irq_to_ctrl raised");
    wr(0, 12'h308, 32'h0000_0012, 1);
    rd(1, 12'h300, 32'h0000_0017, "R3 set ORs");
    wr(1, 12'h310, 32'h0000_0004, 1);
    rd(0, 12'h300, 32'h0000_0013, "R4 clear w1c");

    wr(0, 12'h208, 32'h8000_0000, 1);
    rd(0, 12'h200, 32'h0, "R5 set of bit 31 ignored");
    irqs(0, 1, "R5 irq_to_proc stays low");
    wr(0, 12'h200, 32'h0000_00ff, 1);
    rd(1, 12'h200, 32'h0, "R11 status write ignored");

    wr(0, 12'h208, 32'h0000_000f, 0);
    rd(0, 12'h200, 32'h8000_0000, "R6 non-secure set flags only");
    irqs(1, 1, "R9 irq_to_proc from flag");
    wr(1, 12'h210, 32'h7fff_ffff, 1);
    rd(0, 12'h200, 32'h8000_0000, "R7 flag survives slot clear");
    wr(1, 12'h210, 32'h8000_0000, 0);
    rd(0, 12'h200, 32'h8000_0000, "R7 flag survives non-secure clear");
    wr2(12'h200, 1, 32'h0, 0, 12'h210, 1, 32'h8000_0000, 1);
    rd(0, 12'h200, 32'h8000_0000, "R8 ns attempt beats flag clear");
    wr(1, 12'h210, 32'h8000_0000, 1);
    rd(0, 12'h200, 32'h0, "R7 secure clear of flag");
    irqs(0, 1, "R9 irq_to_proc dropped");

    wr2(12'h308, 1, 32'h0000_0001, 1, 12'h310, 1, 32'h0000_0003, 1);
    rd(1, 12'h300, 32'h0000_0011, "R8 set beats clear");

    rd(0, 12'h308, 32'h0, "R10 set offset reads 0");
    rd(0, 12'h310, 32'h0, "R10 clear offset reads 0");
    rd(1, 12'h000, 32'h0, "R10 unmapped reads 0");
    rd(1, 12'h204, 32'h0, "R10 unmapped near status");
    rd(0, 12'h300, 32'h0000_0011, "R10 reads left status intact");

    wr(1, 12'h208, 32'h4000_0000, 1);
    rd(0, 12'h200, 32'h4000_0000, "R2 ctrl port rings 0x200 channel");
    wr(0, 12'h310, 32'hffff_ffff, 1);
    rd(1, 12'h300, 32'h0, "R2 proc port clears 0x300 channel");
    irqs(1, 0, "R9 irq_to_ctrl dropped");

    repeat (2) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule